// File: doc/BRIEF.md
# Cascadable Programmable Delay Line

This block is a clocked model of a programmable delay element. A single-bit signal, gated by an input enable, passes through a history register. It comes out a selectable number of clock cycles later as a true and complemented pair. The delay is set by an eight-bit control word. Seven of its bits form a binary tap code in which each unit is one clock cycle. The eighth bit only steers cascading. The word is held by transparent capture stages: they follow the word while the capture enable is high and keep their value while it is low.

Two override inputs bypass the tap code. The minimum-force input clears every control bit and gives zero delay. The maximum-force input clears the two lowest select bits, sets the other five and adds one full step (four units), which gives 128 cycles no matter what the select bus carries. The captured eighth bit is driven out as a complementary chain pair.

To chain two instances, wire the first stage's inverted chain output to the second stage's minimum-force and its true chain output to the first stage's own maximum-force. Share the seven select lines between both stages. A low top bit then leaves the first stage in charge and pins the second stage at zero delay. A high top bit saturates the first stage at 128 cycles and passes the select bus to the second stage.

Top module: `stepdelay`

## Requirements
- R1: A synchronous reset clears the delay history and all eight captured control bits. With `ctl_open`, `hold_lo` and `hold_hi` low after reset, the tap is 0, `chain_out` is 0 and `chain_out_n` is 1.
- R2: The tap code is bits 6..0 of the captured word, with bit i worth 2^i cycles. With no override active, a tap of N (0 to 127) makes `dly_out` equal the gated input of N clock edges earlier, and N = 0 passes the current gated input straight through.
- R3: While `ctl_open` is high, the captured word follows `ctl_word` and takes effect in the same cycle. While it is low, the captured word keeps its last value and changes on `ctl_word` have no effect.
- R4: While `hold_lo` is high, the delay is 0 and `ctl_word` is ignored. All eight captured bits are cleared, and they stay cleared after `hold_lo` falls if `ctl_open` is low.
- R5: While `hold_hi` is high and `hold_lo` is low, the delay is 128 cycles whatever `select` holds. Captured bits 1..0 are cleared and bits 6..2 are set, so after `hold_hi` falls with `ctl_open` low the delay is 124. Bit 7 is not affected by `hold_hi`.
- R6: When `hold_lo` and `hold_hi` are both high, the minimum force wins.
- R7: `chain_out` equals captured bit 7, and `chain_out_n` is its inverse.
- R8: While `sig_en` is low, the signal entering the delay is 0, so `dly_out` falls to 0 once the current delay has elapsed.
- R9: `dly_out_n` is always the complement of `dly_out`.
- R10: In a two-stage chain wired as above, the total delay is N when the top bit is 0 and 128 + N when it is 1, where N is the shared select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Signal to delay |
| sig_en | input | 1 | Input enable; low forces the delayed stream to 0 |
| ctl_open | input | 1 | Capture enable for the control word (transparent when high) |
| hold_lo | input | 1 | Force minimum delay, clear captured bits |
| hold_hi | input | 1 | Force maximum delay (128 cycles) |
| ctl_word | input | 8 | Bits 6..0 tap code, bit 7 chain control |
| dly_out | output | 1 | Delayed signal |
| dly_out_n | output | 1 | Complement of the delayed signal |
| chain_out | output | 1 | Captured bit 7 |
| chain_out_n | output | 1 | Complement of captured bit 7 |

## Verification
The properties assume that reset is asserted at start-up, so that the hold property only compares cycles that follow a released reset. They also assume that the force and capture inputs are plain synchronous levels that do not change within a clock period. The bench changes every input shortly after the falling edge and keeps reset high for the first cycles. The cascade stimulus changes the shared select bus only with `ctl_open` held high and then waits longer than the longest combined delay before it compares, because the second stage's history must first fill with output produced under the new setting.

// File: rtl/stepdelay_pkg.sv
package stepdelay_pkg;
    localparam int SEL_W  = 7;
    localparam int CTL_W  = SEL_W + 1;
    localparam int TAP_W  = SEL_W + 1;
    localparam int FINE_W = 2;
    localparam int DEPTH  = 1 << SEL_W;

    typedef enum logic [1:0] {
        OVR_NONE = 2'd0,
        OVR_MIN  = 2'd1,
        OVR_MAX  = 2'd2
    } ovr_e;

    typedef struct packed {
        logic             chain;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    function automatic ovr_e pick_ovr(input logic lo, input logic hi);
        if (lo)
            return OVR_MIN;
        if (hi)
            return OVR_MAX;
        return OVR_NONE;
    endfunction
endpackage

// File: rtl/stepdelay_ctl.sv
module stepdelay_ctl
    import stepdelay_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic open,
    input  ovr_e ovr,
    input  ctl_t din,
    output ctl_t cur
);
    ctl_t             held;
    ctl_t             pass;
    logic [SEL_W-1:0] sel_v;

    assign pass = open ? din : held;

    for (genvar i = 0; i < SEL_W; i++) begin : g_bit
        if (i < FINE_W) begin : g_fine
            assign sel_v[i] = (ovr == OVR_NONE) ? pass.sel[i] : 1'b0;
        end else begin : g_coarse
            assign sel_v[i] = (ovr == OVR_MIN) ? 1'b0 :
                              (ovr == OVR_MAX) ? 1'b1 : pass.sel[i];
        end
    end

    assign cur.sel   = sel_v;
    assign cur.chain = (ovr == OVR_MIN) ? 1'b0 : pass.chain;

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else
            held <= cur;
    end
endmodule

// File: rtl/stepdelay_tap.sv
module stepdelay_tap
    import stepdelay_pkg::*;
(
    input  ovr_e             ovr,
    input  logic [SEL_W-1:0] sel,
    output logic [TAP_W-1:0] tap
);
    localparam logic [TAP_W-1:0] EXTRA = TAP_W'(1 << FINE_W);

    always_comb begin
        tap = {1'b0, sel};
        if (ovr == OVR_MAX)
            tap = {1'b0, sel} + EXTRA;
    end
endmodule

// File: rtl/stepdelay_line.sv
module stepdelay_line #(
    parameter int DEPTH = 128,
    parameter int TAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [TAP_W-1:0] tap,
    output logic             q
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] hist;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst)
            hist <= '0;
        else
            hist <= {hist[DEPTH-2:0], din};
    end

    assign idx = IDX_W'(tap - TAP_W'(1));
    assign q   = (tap == '0) ? din : hist[idx];
endmodule

// File: rtl/stepdelay.sv
module stepdelay
    import stepdelay_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_in,
    input  logic             sig_en,
    input  logic             ctl_open,
    input  logic             hold_lo,
    input  logic             hold_hi,
    input  logic [CTL_W-1:0] ctl_word,
    output logic             dly_out,
    output logic             dly_out_n,
    output logic             chain_out,
    output logic             chain_out_n
);
    ovr_e             ovr;
    ctl_t             cur;
    logic [TAP_W-1:0] tap;
    logic             gated;

    assign ovr   = pick_ovr(hold_lo, hold_hi);
    assign gated = sig_in & sig_en;

    stepdelay_ctl u_ctl (
        .clk  (clk),
        .rst  (rst),
        .open (ctl_open),
        .ovr  (ovr),
        .din  (ctl_t'(ctl_word)),
        .cur  (cur)
    );

    stepdelay_tap u_tap (
        .ovr (ovr),
        .sel (cur.sel),
        .tap (tap)
    );

    stepdelay_line #(.DEPTH(DEPTH), .TAP_W(TAP_W)) u_line (
        .clk (clk),
        .rst (rst),
        .din (gated),
        .tap (tap),
        .q   (dly_out)
    );

    assign dly_out_n   = ~dly_out;
    assign chain_out   = cur.chain;
    assign chain_out_n = ~cur.chain;
endmodule

// File: rtl/stepdelay_chk.sv
module stepdelay_chk #(
    parameter int TAP_W = 8,
    parameter int DEPTH = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             sig_in,
    input logic             sig_en,
    input logic             ctl_open,
    input logic             hold_lo,
    input logic             hold_hi,
    input logic [7:0]       ctl_word,
    input logic             dly_out,
    input logic             chain_out,
    input logic [TAP_W-1:0] tap
);
    // R4: forced minimum passes the gated input straight through
    p_min_thru_r4: assert property (@(posedge clk) disable iff (rst)
        hold_lo |-> (dly_out == (sig_in && sig_en)));

    // R5: forced maximum selects the full range plus one step
    p_max_tap_r5: assert property (@(posedge clk) disable iff (rst)
        (hold_hi && !hold_lo) |-> (tap == TAP_W'(DEPTH)));

    // R6: minimum force wins over maximum force
    p_min_prio_r6: assert property (@(posedge clk) disable iff (rst)
        (hold_lo && hold_hi) |-> (tap == '0));

    // R3: closed capture keeps the chain bit
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctl_open && !hold_lo && !$past(rst)) |-> (chain_out == $past(chain_out)));

    // R7: open capture forwards bit 7 to the chain output
    p_chain_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_open && !hold_lo) |-> (chain_out == ctl_word[7]));

    // R8: disabled input with zero tap gives a low output
    p_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (!sig_en && tap == '0) |-> !dly_out);
endmodule

bind stepdelay stepdelay_chk #(
    .TAP_W (stepdelay_pkg::TAP_W),
    .DEPTH (stepdelay_pkg::DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sig_in    (sig_in),
    .sig_en    (sig_en),
    .ctl_open  (ctl_open),
    .hold_lo   (hold_lo),
    .hold_hi   (hold_hi),
    .ctl_word  (ctl_word),
    .dly_out   (dly_out),
    .chain_out (chain_out),
    .tap       (tap)
);

// File: tb/sim_stepdelay.sv
`timescale 1ns/1ps
module sim_stepdelay;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sig_in = 1'b0;
    logic       sig_en = 1'b1;
    logic       ctl_open = 1'b0;
    logic       hold_lo = 1'b0;
    logic       hold_hi = 1'b0;
    logic [7:0] ctl_word = 8'h00;
    logic       dly_out, dly_out_n, chain_out, chain_out_n;

    // two-stage chain
    logic [7:0] chbus = 8'h00;
    logic       c1_q, c1_qn, c1_ch, c1_chn;
    logic       c2_q, c2_qn, c2_ch, c2_chn;

    always #4 clk = ~clk;

    stepdelay u0 (
        .clk(clk), .rst(rst), .sig_in(sig_in), .sig_en(sig_en),
        .ctl_open(ctl_open), .hold_lo(hold_lo), .hold_hi(hold_hi),
        .ctl_word(ctl_word), .dly_out(dly_out), .dly_out_n(dly_out_n),
        .chain_out(chain_out), .chain_out_n(chain_out_n)
    );

    stepdelay c1 (
        .clk(clk), .rst(rst), .sig_in(sig_in), .sig_en(1'b1),
        .ctl_open(1'b1), .hold_lo(1'b0), .hold_hi(c1_ch),
        .ctl_word(chbus), .dly_out(c1_q), .dly_out_n(c1_qn),
        .chain_out(c1_ch), .chain_out_n(c1_chn)
    );

    stepdelay c2 (
        .clk(clk), .rst(rst), .sig_in(c1_q), .sig_en(1'b1),
        .ctl_open(1'b1), .hold_lo(c1_chn), .hold_hi(1'b0),
        .ctl_word({1'b0, chbus[6:0]}), .dly_out(c2_q), .dly_out_n(c2_qn),
        .chain_out(c2_ch), .chain_out_n(c2_chn)
    );

    int          vec = 0;
    int          bad = 0;
    string       req = "R1";
    logic [127:0] mh = '0;
    logic [255:0] ch_h = '0;
    logic [7:0]  held_m = '0;
    logic [15:0] lfsr = 16'hACE1;
    bit          chain_on = 1'b0;
    int          chain_wait = 0;
    int          chain_tot = 0;

    task automatic cyc();
        logic       gi;
        logic       e;
        logic       ce;
        logic [7:0] lat;
        logic [7:0] tp;
        bit         miss;
        #1;
        gi = sig_in & sig_en;
        if (hold_lo)
            lat = 8'h00;
        else begin
            lat = ctl_open ? ctl_word : held_m;
            if (hold_hi)
                lat[6:0] = 7'b1111100;
        end
        tp = (hold_hi && !hold_lo) ? 8'd128 : {1'b0, lat[6:0]};
        e = (tp == 8'd0) ? gi : mh[tp - 8'd1];
        miss = 1'b0;
        vec++;
        if (dly_out !== e) begin
            $display("FAIL %s dly_out act=%b exp=%b tap=%0d", req, dly_out, e, tp);
            miss = 1'b1;
        end
        if (dly_out_n !== ~e) begin
            $display("FAIL R9 dly_out_n act=%b exp=%b", dly_out_n, ~e);
            miss = 1'b1;
        end
        if (chain_out !== lat[7] || chain_out_n !== ~lat[7]) begin
            $display("FAIL R7 chain pair act=%b%b exp=%b%b", chain_out, chain_out_n, lat[7], ~lat[7]);
            miss = 1'b1;
        end
        if (miss)
            bad++;
        if (chain_on) begin
            if (chain_wait > 0)
                chain_wait--;
            else begin
                ce = (chain_tot == 0) ? sig_in : ch_h[chain_tot - 1];
                vec++;
                if (c2_q !== ce) begin
                    $display("FAIL R10 chain out act=%b exp=%b total=%0d", c2_q, ce, chain_tot);
                    bad++;
                end
            end
        end
        @(posedge clk);
        if (rst) begin
            mh     = '0;
            ch_h   = '0;
            held_m = '0;
        end else begin
            mh     = {mh[126:0], gi};
            ch_h   = {ch_h[254:0], sig_in};
            held_m = lat;
        end
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            sig_in = lfsr[0];
            lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc();
        end
    endtask

    task automatic hold_low(input int n);
        for (int k = 0; k < n; k++) begin
            sig_in = 1'b0;
            cyc();
        end
    endtask

    initial begin
        #(150000 * 8);
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state with quiet inputs
        req = "R1";
        hold_low(3);
        // fill history with activity, then reset and confirm it is gone
        rst = 1'b0;
        ctl_word = 8'h32; ctl_open = 1'b1;
        run(1);
        ctl_open = 1'b0;
        for (int k = 0; k < 60; k++) begin sig_in = 1'b1; cyc(); end
        rst = 1'b1;
        hold_low(1);
        rst = 1'b0;
        hold_low(3);
        ctl_word = 8'h32; ctl_open = 1'b1;
        hold_low(1);
        ctl_open = 1'b0;
        hold_low(10);

        // R2 with R3: sweep every tap, scramble the bus while closed
        for (int n = 0; n < 128; n++) begin
            req = "R2";
            ctl_word = {1'b0, 7'(n)};
            ctl_open = 1'b1;
            run(1);
            ctl_open = 1'b0;
            req = "R3";
            ctl_word = ~8'(n);
            run(n + 4);
        end

        // R8: enable low drains the delay line
        req = "R8";
        ctl_word = 8'd20; ctl_open = 1'b1; run(1); ctl_open = 1'b0;
        run(25);
        sig_en = 1'b0;
        run(30);
        sig_en = 1'b1;
        run(5);

        // R4: forced minimum, select ignored, bits stay cleared
        req = "R4";
        ctl_word = 8'hFF; ctl_open = 1'b1; run(2);
        hold_lo = 1'b1;
        for (int k = 0; k < 10; k++) begin ctl_word = 8'(k * 37); run(1); end
        ctl_open = 1'b0;
        run(2);
        hold_lo = 1'b0;
        ctl_word = 8'hFF;
        run(6);

        // R5: forced maximum, then release to 124
        req = "R5";
        ctl_word = 8'h83; ctl_open = 1'b1; run(1); ctl_open = 1'b0;
        hold_hi = 1'b1;
        for (int k = 0; k < 140; k++) begin ctl_word = 8'(k); run(1); end
        hold_hi = 1'b0;
        run(130);

        // R6: both forces together
        req = "R6";
        hold_lo = 1'b1; hold_hi = 1'b1;
        run(12);
        hold_lo = 1'b0; hold_hi = 1'b0;
        run(4);

        // R7: chain bit follows capture
        req = "R7";
        for (int k = 0; k < 6; k++) begin
            ctl_word = {k[0], 7'd3}; ctl_open = 1'b1; run(1);
            ctl_open = 1'b0; ctl_word = {~k[0], 7'd9}; run(3);
        end

        // R10: two-stage chain totals
        req = "R10";
        chain_on = 1'b1;
        chbus = {1'b0, 7'd37}; chain_tot = 37;       chain_wait = 270; run(290);
        chbus = {1'b1, 7'd37}; chain_tot = 128 + 37; chain_wait = 270; run(290);
        chbus = {1'b1, 7'd127}; chain_tot = 255;     chain_wait = 270; run(290);
        chbus = {1'b0, 7'd0};  chain_tot = 0;        chain_wait = 270; run(290);
        chain_on = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule